// File: doc/BRIEF.md
# Toggle-Clocked Programmable Logic Element

This block is one programmable cell of a logic fabric. A 4-input look-up table is paired with a single storage bit that can only invert. The storage bit advances on a clock edge only when the table output is high in that cycle. Otherwise it holds, and no event reaches it. One table input can be assigned to carry the cell's own stored bit back into the table. A sequential function then needs no routed feedback, and the external signal on that position is ignored.

The table contents are loaded while reset is held. They can be given in toggle form, meaning "invert now", and are then stored as given. They can also be given in the form a plain D-register cell would use, meaning "next value". In that case a converter rewrites them at load time into the equivalent toggle form, so that the cell matches the D-register cell cycle for cycle.

The element exposes three outputs: the raw table output, the stored bit, and a selected output. It also keeps a wrapping count of the cycles in which the storage bit was allowed to change.

Top module: `tcle_logic_element`

## Requirements
- R1: On a rising clock edge with `rst_n` low, the stored bit `reg_out` and the event count `toggle_count` both become 0.
- R2: The mask, the feedback-position select and the mask format are captured only on edges where `rst_n` is low. Changing `cfg_mask`, `fb_sel` or `cfg_dstyle` while `rst_n` is high has no effect on any output.
- R3: With toggle-form contents (`cfg_dstyle` = 0 at load), `comb_out` equals bit `k` of the stored mask. Here bit `j` of index `k` is `lut_in[j]`, except at position `fb_sel`, where it is the present `reg_out`.
- R4: On each edge with `rst_n` high, `reg_out` becomes its previous value XOR the `comb_out` of that cycle.
- R5: The external input at the selected feedback position has no influence on `comb_out`.
- R6: With D-form contents (`cfg_dstyle` = 1 at load), on each edge with `rst_n` high, `reg_out` takes bit `k` of the loaded D mask, with `k` formed as in R3.
- R7: With D-form contents, `comb_out` is 1 exactly when the D mask bit at index `k` differs from the present `reg_out`, and 0 when they are equal.
- R8: `sel_out` equals `reg_out` when `out_sel` is 1 and `comb_out` when `out_sel` is 0.
- R9: `toggle_count` grows by one, modulo 2^CNT_W, on each edge with `rst_n` high where `comb_out` is 1. It therefore equals the number of `reg_out` changes since reset, modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset; also the configuration load window |
| lut_in | input | N_IN | External table inputs |
| cfg_mask | input | 2**N_IN | Table contents, toggle or D form |
| fb_sel | input | $clog2(N_IN) | Table input position that carries the stored bit |
| cfg_dstyle | input | 1 | 1: `cfg_mask` is in D form and is converted at load |
| out_sel | input | 1 | Output selector: 1 picks the stored bit |
| comb_out | output | 1 | Table output (the toggle enable) |
| reg_out | output | 1 | Stored bit |
| sel_out | output | 1 | Selected output |
| toggle_count | output | CNT_W | Wrapping count of enabled cycles |

## Verification
Every combination of feedback position and mask format is run against six masks: all zeros, all ones, parity, a single-input copy, an upper-half mask and an irregular one. Each run applies a scrambled input sequence that covers all sixteen input values. Constant masks separate "never moves" from "moves every cycle". Parity and the single-input copy show whether the stored bit really replaces the chosen input position. The D-form runs test the converter against an independent next-state model, and the toggle-form runs test the raw table. Two further checks run in every cycle. First, the configuration inputs are driven with wrong values after reset, which tests load gating. Second, the ignored input position is flipped, which tests feedback substitution. A narrow counter lets the event count wrap within one run.

// File: rtl/tcle_pkg.sv
// Shared encodings for the toggle-clocked logic element.
// Assumes: imported by every module of the element.
package tcle_pkg;

    // Form in which the table contents are supplied at load time.
    typedef enum logic {
        MASK_TOGGLE = 1'b0,
        MASK_DLIKE  = 1'b1
    } mask_fmt_e;

    // Source of the selected output.
    typedef enum logic {
        OUT_COMB = 1'b0,
        OUT_REG  = 1'b1
    } out_src_e;

endpackage

// File: rtl/tcle_mask_conv.sv
// Converts a D-form table mask into the toggle form that gives the same
// next state. For each index, the bit seen at the feedback position is the
// present state, so XOR-ing the mask bit with that index bit yields "invert now".
// Assumes: fb is a valid input position below N_IN.
module tcle_mask_conv
    import tcle_pkg::*;
#(
    parameter int N_IN = 4
) (
    input  logic [(1 << N_IN)-1:0]    mask_in,
    input  logic [$clog2(N_IN)-1:0]   fb,
    input  mask_fmt_e                 fmt,
    output logic [(1 << N_IN)-1:0]    mask_out
);

    localparam int MW = 1 << N_IN;

    // One XOR per table entry, against that entry's own index bit.
    for (genvar i = 0; i < MW; i++) begin : g_entry
        localparam logic [N_IN-1:0] IDX = N_IN'(i);
        assign mask_out[i] = mask_in[i] ^ ((fmt == MASK_DLIKE) & IDX[fb]);
    end

endmodule

// File: rtl/tcle_cfg_store.sv
// Holds the table contents and the feedback position.
// Loads only while reset is asserted.
// Assumes: configuration inputs are settled during the reset window.
module tcle_cfg_store #(
    parameter int N_IN = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [(1 << N_IN)-1:0]    mask_in,
    input  logic [$clog2(N_IN)-1:0]   fb_in,
    output logic [(1 << N_IN)-1:0]    mask_q,
    output logic [$clog2(N_IN)-1:0]   fb_q
);

    // Capture the configuration during reset; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= mask_in;
            fb_q   <= fb_in;
        end
    end

endmodule

// File: rtl/tcle_lut.sv
// Look-up table with the stored bit substituted at one input position.
// Assumes: fb selects a position below N_IN; purely combinational.
module tcle_lut #(
    parameter int N_IN = 4
) (
    input  logic [N_IN-1:0]           ext_in,
    input  logic                      state,
    input  logic [$clog2(N_IN)-1:0]   fb,
    input  logic [(1 << N_IN)-1:0]    mask,
    output logic                      lut_out
);

    localparam int SW = $clog2(N_IN);

    logic [N_IN-1:0] idx;

    // Per-position choice between the external input and the stored bit.
    for (genvar k = 0; k < N_IN; k++) begin : g_pos
        assign idx[k] = (fb == SW'(k)) ? state : ext_in[k];
    end

    // Table read.
    assign lut_out = mask[idx];

endmodule

// File: rtl/tcle_toggle_cell.sv
// Storage bit that can only invert, plus a wrapping count of the cycles in
// which inverting was enabled. The gated clock is modelled as a synchronous
// toggle enable on the single system clock.
// Assumes: toggle_en is settled before each rising edge.
module tcle_toggle_cell #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             toggle_en,
    output logic             q,
    output logic [CNT_W-1:0] count
);

    // Invert the stored bit when enabled; clear it in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else if (toggle_en) q <= ~q;
    end

    // Count the enabled cycles; wrap freely.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else if (toggle_en) count <= count + 1'b1;
    end

endmodule

// File: rtl/tcle_logic_element.sv
// Toggle-clocked programmable logic element: configuration store with
// load-time mask conversion, look-up table with state feedback, toggle storage
// bit and output selector.
// Assumes: N_IN >= 2; configuration is applied while rst_n is low.
module tcle_logic_element
    import tcle_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int CNT_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_IN-1:0]           lut_in,
    input  logic [(1 << N_IN)-1:0]    cfg_mask,
    input  logic [$clog2(N_IN)-1:0]   fb_sel,
    input  logic                      cfg_dstyle,
    input  logic                      out_sel,
    output logic                      comb_out,
    output logic                      reg_out,
    output logic                      sel_out,
    output logic [CNT_W-1:0]          toggle_count
);

    localparam int MW = 1 << N_IN;
    localparam int SW = $clog2(N_IN);

    logic [MW-1:0] conv_mask;
    logic [MW-1:0] mask_q;
    logic [SW-1:0] fb_q;

    tcle_mask_conv #(.N_IN(N_IN)) u_conv (
        .mask_in  (cfg_mask),
        .fb       (fb_sel),
        .fmt      (mask_fmt_e'(cfg_dstyle)),
        .mask_out (conv_mask)
    );

    tcle_cfg_store #(.N_IN(N_IN)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_in (conv_mask),
        .fb_in   (fb_sel),
        .mask_q  (mask_q),
        .fb_q    (fb_q)
    );

    tcle_lut #(.N_IN(N_IN)) u_lut (
        .ext_in  (lut_in),
        .state   (reg_out),
        .fb      (fb_q),
        .mask    (mask_q),
        .lut_out (comb_out)
    );

    tcle_toggle_cell #(.CNT_W(CNT_W)) u_cell (
        .clk       (clk),
        .rst_n     (rst_n),
        .toggle_en (comb_out),
        .q         (reg_out),
        .count     (toggle_count)
    );

    // Output selector.
    always_comb begin
        if (out_src_e'(out_sel) == OUT_REG) sel_out = reg_out;
        else                                sel_out = comb_out;
    end

endmodule

// File: rtl/tcle_checker.sv
// Property checker for the toggle-clocked logic element, attached by bind.
// Assumes: sampled on the element's clock; rst_n low at the first edge.
module tcle_checker #(
    parameter int N_IN  = 4,
    parameter int CNT_W = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      comb_out,
    input logic                      reg_out,
    input logic [CNT_W-1:0]          toggle_count,
    input logic [(1 << N_IN)-1:0]    cfg_mask_q,
    input logic [$clog2(N_IN)-1:0]   cfg_fb_q
);

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (reg_out == 1'b0 && toggle_count == '0)); // R1

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($stable(cfg_mask_q) && $stable(cfg_fb_q))); // R2

    AST_TOGGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (reg_out == ($past(reg_out) ^ $past(comb_out)))); // R4

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (toggle_count == ($past(toggle_count)
                  + {{(CNT_W-1){1'b0}}, $past(comb_out)}))); // R9

    AST_COUNT_TRACKS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((reg_out != $past(reg_out)) == (toggle_count != $past(toggle_count)))); // R9

endmodule

bind tcle_logic_element tcle_checker #(.N_IN(N_IN), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .comb_out     (comb_out),
    .reg_out      (reg_out),
    .toggle_count (toggle_count),
    .cfg_mask_q   (mask_q),
    .cfg_fb_q     (fb_q)
);

// File: tb/tcle_logic_element_tb.sv
// Sweeps masks x feedback positions x mask formats against a bench model.
module tcle_logic_element_tb;

    localparam int N_IN  = 4;
    localparam int MW    = 16;
    localparam int SW    = 2;
    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N_IN-1:0]  lut_in = '0;
    logic [MW-1:0]    cfg_mask = '0;
    logic [SW-1:0]    fb_sel = '0;
    logic             cfg_dstyle = 1'b0;
    logic             out_sel = 1'b0;
    logic             comb_out, reg_out, sel_out;
    logic [CNT_W-1:0] toggle_count;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #5 clk = ~clk;

    tcle_logic_element #(.N_IN(N_IN), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .lut_in(lut_in), .cfg_mask(cfg_mask),
        .fb_sel(fb_sel), .cfg_dstyle(cfg_dstyle), .out_sel(out_sel),
        .comb_out(comb_out), .reg_out(reg_out), .sel_out(sel_out),
        .toggle_count(toggle_count)
    );

    // Compare one value and report a mismatch.
    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Run one configuration: load in reset, then step with a model.
    task automatic run_cfg(input logic [MW-1:0] mask, input int fb, input bit dfmt, input int seed);
        logic            q;
        int              cnt;
        logic [N_IN-1:0] idx;
        logic [N_IN-1:0] in_v;
        logic            en;
        logic            nq;
        @(negedge clk);
        rst_n = 1'b0; cfg_mask = mask; fb_sel = SW'(fb); cfg_dstyle = dfmt;
        @(negedge clk);
        @(negedge clk);
        chk("R1 reg_out", int'(reg_out), 0);
        chk("R1 count", int'(toggle_count), 0);
        rst_n = 1'b1;
        // R2: wrong configuration on the inputs after reset must be ignored
        cfg_mask = ~mask ^ 16'h5a3c; fb_sel = SW'(fb + 1); cfg_dstyle = ~dfmt;
        q = 1'b0; cnt = 0;
        for (int c = 0; c < 40; c++) begin
            in_v = N_IN'((c * 7 + 3) ^ (c >> 2) ^ seed);
            lut_in = in_v; out_sel = c[0];
            #1;
            idx = in_v; idx[fb] = q;
            if (dfmt) begin nq = mask[idx]; en = nq ^ q; end
            else      begin en = mask[idx]; nq = q ^ en; end
            chk(dfmt ? "R2 R7 comb_out" : "R2 R3 comb_out", int'(comb_out), int'(en));
            chk("R8 sel_out", int'(sel_out), int'(c[0] ? q : en));
            lut_in[fb] = ~lut_in[fb];
            #1;
            chk("R5 comb_out", int'(comb_out), int'(en));
            @(negedge clk);
            q = nq; cnt = (cnt + int'(en)) % 16;
            chk(dfmt ? "R6 reg_out" : "R4 reg_out", int'(reg_out), int'(q));
            chk("R9 count", int'(toggle_count), cnt);
        end
    endtask

    // Main sweep.
    initial begin
        logic [MW-1:0] pats [6];
        pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'h6996;
        pats[3] = 16'hAAAA; pats[4] = 16'hFF00; pats[5] = 16'hB4E1;
        for (int p = 0; p < 6; p++)
            for (int f = 0; f < N_IN; f++)
                for (int d = 0; d < 2; d++)
                    run_cfg(pats[p], f, d[0], p * 5 + f);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule